// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 memory from power-on to normal operation in hardware, with no processor involvement. A single start pulse launches a fixed series of commands on a narrow command bus. Each command is a one-cycle strobe carrying a 3-bit command code and a 3-bit bank address. The series opens with two NOP commands separated by a 500 µs stabilization wait. It then writes the extended mode registers in the order 2, 3, 1, turns on the DLL-enable control, writes the main mode register, starts ZQ calibration, and returns the device to normal mode.

As its last action the block latches the refresh interval in clock cycles and raises a done flag, which stays high until reset. The stabilization wait is worked out from the clock frequency input, given in kHz. Between any two commands the bus idles for at least `MIN_GAP` cycles, and whenever the strobe is low the bus shows NOP with bank address zero.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While reset is held and after its release, `cmd_valid_o`=0, `cmd_code_o`=NOP (3'd1), `cmd_ba_o`=0, `dll_en_o`=0, `refresh_cnt_o`=0 and `done_o`=0.
- R2: Strobes occur in this order as (code, bank): NOP(1,0), NOP(1,0), EXT-MODE(5,2), EXT-MODE(5,3), EXT-MODE(5,1), LOAD-MODE(3,0), ZQ-CAL(6,0), NORMAL(0,0). No further strobe follows.
- R3: Every strobe lasts one cycle. The first strobe comes 2 cycles after the clock edge that samples `start_i`. Consecutive strobes are `MIN_GAP`+1 cycles apart, except for the two cases given in R4 and R6.
- R4: The stabilization wait is W = (clk_khz_i × 500 + 500) / 1000 cycles, in integer arithmetic. The second NOP strobe comes W + `MIN_GAP` + 2 cycles after the first, and no strobe occurs in between.
- R5: Whenever `cmd_valid_o` is low, `cmd_code_o` reads NOP (3'd1) and `cmd_ba_o` reads 0.
- R6: `dll_en_o` is 0 at all three EXT-MODE strobes and 1 at the LOAD-MODE strobe. The LOAD-MODE strobe comes 2×(`MIN_GAP`+1) cycles after the bank-1 EXT-MODE strobe. Once high, `dll_en_o` stays high until reset.
- R7: `done_o` rises `MIN_GAP`+1 cycles after the NORMAL strobe. At that moment `refresh_cnt_o` becomes trefi_i / tck_i (integer floor), or 0 if tck_i is 0. Before that moment it reads 0.
- R8: Once high, `done_o` stays high until reset, and no strobe occurs after it.
- R9: A start pulse while the sequence runs, or after done, has no effect on the strobe series or its timing.
- R10: With `start_i` low after reset, no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that launches the sequence |
| clk_khz_i | input | KHZ_W (20) | Clock frequency in kHz, used for the stabilization wait |
| trefi_i | input | REF_W (32) | Refresh interval, in the same time unit as tck_i |
| tck_i | input | TCK_W (16) | Clock period |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 3 | Command code (0 normal, 1 NOP, 3 load mode, 5 extended mode, 6 ZQ cal) |
| cmd_ba_o | output | 3 | Bank address sent with the command |
| dll_en_o | output | 1 | DLL-enable control |
| refresh_cnt_o | output | REF_W (32) | Refresh interval in cycles, loaded at the end |
| done_o | output | 1 | Sequence complete, held until reset |

## Verification
The assertions assume that `clk_khz_i`, `trefi_i` and `tck_i` stay fixed from the start pulse until done. The bench sets these inputs during reset and leaves them alone for the rest of each run. The assertions also assume that reset is the only way back to the idle state, so the bench applies a fresh reset before each run and never relies on a second start pulse. Extra start pulses are sent during the stabilization wait and after done, to show that the sequence ignores them.

// File: rtl/ddr3_bringup_pkg.sv
package ddr3_bringup_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL   = 3'd0,
    CMD_NOP      = 3'd1,
    CMD_LOADMODE = 3'd3,
    CMD_EXTMODE  = 3'd5,
    CMD_ZQCAL    = 3'd6
  } cmd_code_e;

  localparam int unsigned NUM_STEPS = 10;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
  localparam int unsigned STAB_US   = 500;

  typedef struct packed {
    logic      strobe;
    cmd_code_e code;
    logic [2:0] ba;
    logic      dll_on;
    logic      long_wait;
    logic      last;
  } step_info_t;

  // Round-to-nearest cycle count for a delay in microseconds at a kHz clock.
  function automatic logic [63:0] stab_ticks(input logic [63:0] khz, input logic [63:0] us);
    return (khz * us + 64'd500) / 64'd1000;
  endfunction

  // Refresh interval in cycles; zero when the clock period is zero.
  function automatic logic [63:0] refresh_ratio(input logic [63:0] trefi, input logic [63:0] tck);
    return (tck == 64'd0) ? 64'd0 : trefi / tck;
  endfunction

endpackage

// File: rtl/bringup_step_decode.sv
module bringup_step_decode
  import ddr3_bringup_pkg::*;
#(
  parameter int unsigned SW = STEP_W
) (
  input  logic [SW-1:0] step_idx_i,
  output step_info_t    info_o
);

  always_comb begin
    info_o = '{strobe: 1'b0, code: CMD_NOP, ba: 3'd0,
               dll_on: 1'b0, long_wait: 1'b0, last: 1'b0};
    unique case (step_idx_i)
      SW'(0): begin info_o.strobe = 1'b1; info_o.long_wait = 1'b1; end
      SW'(1): info_o.strobe = 1'b1;
      SW'(2): begin info_o.strobe = 1'b1; info_o.code = CMD_EXTMODE; info_o.ba = 3'd2; end
      SW'(3): begin info_o.strobe = 1'b1; info_o.code = CMD_EXTMODE; info_o.ba = 3'd3; end
      SW'(4): begin info_o.strobe = 1'b1; info_o.code = CMD_EXTMODE; info_o.ba = 3'd1; end
      SW'(5): info_o.dll_on = 1'b1;
      SW'(6): begin info_o.strobe = 1'b1; info_o.code = CMD_LOADMODE; end
      SW'(7): begin info_o.strobe = 1'b1; info_o.code = CMD_ZQCAL; end
      SW'(8): begin info_o.strobe = 1'b1; info_o.code = CMD_NORMAL; end
      default: info_o.last = 1'b1;
    endcase
  end

endmodule

// File: rtl/bringup_interval_timer.sv
module bringup_interval_timer #(
  parameter int unsigned W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4
  countdown_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq
  import ddr3_bringup_pkg::*;
#(
  parameter int unsigned KHZ_W   = 20,
  parameter int unsigned REF_W   = 32,
  parameter int unsigned TCK_W   = 16,
  parameter int unsigned MIN_GAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KHZ_W-1:0] clk_khz_i,
  input  logic [REF_W-1:0] trefi_i,
  input  logic [TCK_W-1:0] tck_i,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_code_o,
  output logic [2:0]       cmd_ba_o,
  output logic             dll_en_o,
  output logic [REF_W-1:0] refresh_cnt_o,
  output logic             done_o
);

  localparam int unsigned TICK_W = KHZ_W + 10;
  localparam int unsigned GAP_W  = $clog2(MIN_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_LWAIT, S_GAP, S_DONE} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  step_info_t        info;
  logic              tmr_load, tmr_zero;
  logic [TICK_W-1:0] tmr_val, wait_ticks;
  logic [REF_W-1:0]  ref_val;

  // named internal events
  logic step_fire, wait_over, gap_over, start_seen;

  bringup_step_decode #(.SW(STEP_W)) u_decode (
    .step_idx_i (step_q),
    .info_o     (info)
  );

  assign wait_ticks = TICK_W'(stab_ticks(64'(clk_khz_i), 64'(STAB_US)));
  assign ref_val    = REF_W'(refresh_ratio(64'(trefi_i), 64'(tck_i)));

  assign step_fire  = (state_q == S_STEP);
  assign wait_over  = (state_q == S_LWAIT) && tmr_zero;
  assign gap_over   = (state_q == S_GAP) && tmr_zero;
  assign start_seen = (state_q == S_IDLE) && start_i;

  assign tmr_load = (step_fire && !info.last) || wait_over;
  assign tmr_val  = (step_fire && info.long_wait) ? wait_ticks : TICK_W'(MIN_GAP - 1);

  bringup_interval_timer #(.W(TICK_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      step_q        <= '0;
      cmd_valid_o   <= 1'b0;
      cmd_code_o    <= CMD_NOP;
      cmd_ba_o      <= 3'd0;
      dll_en_o      <= 1'b0;
      refresh_cnt_o <= '0;
      done_o        <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= CMD_NOP;
      cmd_ba_o    <= 3'd0;
      unique case (state_q)
        S_IDLE: if (start_seen) begin
          state_q <= S_STEP;
          step_q  <= '0;
        end
        S_STEP: begin
          cmd_valid_o <= info.strobe;
          cmd_code_o  <= info.code;
          cmd_ba_o    <= info.ba;
          if (info.dll_on) dll_en_o <= 1'b1;
          step_q <= step_q + 1'b1;
          if (info.last) begin
            refresh_cnt_o <= ref_val;
            done_o        <= 1'b1;
            state_q       <= S_DONE;
          end else if (info.long_wait) begin
            state_q <= S_LWAIT;
          end else begin
            state_q <= S_GAP;
          end
        end
        S_LWAIT: if (wait_over) state_q <= S_GAP;
        S_GAP:   if (gap_over)  state_q <= S_STEP;
        default: state_q <= S_DONE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [GAP_W-1:0] idle_run_q;
  logic             seen_strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_run_q    <= '0;
      seen_strobe_q <= 1'b0;
    end else if (cmd_valid_o) begin
      idle_run_q    <= '0;
      seen_strobe_q <= 1'b1;
    end else if (idle_run_q != GAP_W'(MIN_GAP)) begin
      idle_run_q <= idle_run_q + 1'b1;
    end
  end

  // R3
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R3
  strobe_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && seen_strobe_q) |-> (idle_run_q == GAP_W'(MIN_GAP)));

  // R5
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_code_o == CMD_NOP && cmd_ba_o == 3'd0));

  // R4
  quiet_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LWAIT && $past(state_q) == S_LWAIT) |-> !cmd_valid_o);

  // R6
  dll_before_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o == CMD_LOADMODE) |-> dll_en_o);

  // R6
  dll_after_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o == CMD_EXTMODE) |-> !dll_en_o);

  // R6
  dll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_en_o |=> dll_en_o);

  // R2
  ext_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o == CMD_EXTMODE) |-> (cmd_ba_o != 3'd0));

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !cmd_valid_o && $stable(refresh_cnt_o)));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> (state_q != S_IDLE));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> (!cmd_valid_o && !done_o && !dll_en_o));

endmodule

// File: tb/ddr3_bringup_seq_tb_top.sv
module ddr3_bringup_seq_tb_top;

  localparam int G = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] khz = '0;
  logic [31:0] trefi = '0;
  logic [15:0] tck = '0;
  logic        cmd_valid, dll_en, done;
  logic [2:0]  cmd_code, cmd_ba;
  logic [31:0] refresh_cnt;

  always #10 clk = ~clk;  // 50 MHz

  ddr3_bringup_seq #(.MIN_GAP(G)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clk_khz_i(khz),
    .trefi_i(trefi), .tck_i(tck), .cmd_valid_o(cmd_valid),
    .cmd_code_o(cmd_code), .cmd_ba_o(cmd_ba), .dll_en_o(dll_en),
    .refresh_cnt_o(refresh_cnt), .done_o(done)
  );

  typedef struct {
    logic [2:0] code;
    logic [2:0] ba;
    int         delta;
    logic       dll;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   ref_cyc = 0;
  int   last_strobe_cyc = 0;
  int   strobe_count = 0;
  int   checks = 0;
  int   fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      // R5 bus idles at NOP/0 between strobes
      if (!cmd_valid && (cmd_code != 3'd1 || cmd_ba != 3'd0))
        check(1'b0, "R5", "idle bus", {cmd_code, cmd_ba}, 6'b001000);
      if (cmd_valid) begin
        strobe_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected strobe code", cmd_code, 7);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cmd_code == e.code && cmd_ba == e.ba, "R2", "code/bank",
                {cmd_code, cmd_ba}, {e.code, e.ba});
          check(cyc - ref_cyc == e.delta, e.req, "strobe spacing", cyc - ref_cyc, e.delta);
          check(dll_en == e.dll, "R6", "dll enable at strobe", dll_en, e.dll);
        end
        ref_cyc = cyc;
        last_strobe_cyc = cyc;
      end
    end
  end

  task automatic push(input logic [2:0] c, input logic [2:0] b, input int d,
                      input logic dl, input string r);
    exp_t e;
    e.code = c; e.ba = b; e.delta = d; e.dll = dl; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic run_seq(input int k, input int tr, input int tc, input bit poke);
    int  wticks;
    int  exp_ref;
    int  sc;
    bit  early_ref;
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    khz = 20'(k); trefi = 32'(tr); tck = 16'(tc);
    repeat (3) @(negedge clk);
    check(!cmd_valid && cmd_code == 3'd1 && cmd_ba == 0, "R1", "bus in reset", {cmd_valid, cmd_code, cmd_ba}, 7'b0001000);
    check(!dll_en && !done && refresh_cnt == 0, "R1", "flags in reset", {dll_en, done}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(strobe_count == 0 && !done, "R10", "no strobe without start", strobe_count, 0);
    check(cmd_code == 3'd1 && cmd_ba == 0 && refresh_cnt == 0, "R1", "after release", cmd_code, 1);

    wticks  = (k + 1) / 2;                 // 500 us at k kHz, rounded
    exp_ref = (tc == 0) ? 0 : tr / tc;
    push(3'd1, 3'd0, 2,            1'b0, "R3");
    push(3'd1, 3'd0, wticks + G + 2, 1'b0, "R4");
    push(3'd5, 3'd2, G + 1,        1'b0, "R3");
    push(3'd5, 3'd3, G + 1,        1'b0, "R3");
    push(3'd5, 3'd1, G + 1,        1'b0, "R3");
    push(3'd3, 3'd0, 2 * (G + 1),  1'b1, "R6");
    push(3'd6, 3'd0, G + 1,        1'b1, "R3");
    push(3'd0, 3'd0, G + 1,        1'b1, "R3");

    start = 1'b1; ref_cyc = cyc;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (8) @(negedge clk);
      start = 1'b1;               // R9 ignored while running
      @(negedge clk); start = 1'b0;
    end
    early_ref = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (!done && refresh_cnt != 0) early_ref = 1'b1;
    end
    check(!early_ref, "R7", "refresh count zero before done", early_ref, 0);
    check(cyc - last_strobe_cyc == G + 1, "R7", "done delay after normal", cyc - last_strobe_cyc, G + 1);
    check(refresh_cnt == 32'(exp_ref), "R7", "refresh count", refresh_cnt, exp_ref);
    check(exp_q.size() == 0, "R2", "all commands issued", exp_q.size(), 0);
    check(dll_en, "R6", "dll stays on", dll_en, 1);

    sc = strobe_count;
    start = 1'b1;                 // R9 ignored after done
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    check(done, "R8", "done held", done, 1);
    check(strobe_count == sc, "R9", "no strobe after late start", strobe_count, sc);
    check(refresh_cnt == 32'(exp_ref), "R8", "refresh count held", refresh_cnt, exp_ref);
    strobe_count = 0;
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    run_seq(100, 7800000, 2500, 1'b1);   // wait 50, refresh 3120
    run_seq(3, 1000, 3, 1'b1);           // R4 half rounds up: wait 2
    run_seq(1999, 64000, 0, 1'b0);       // wait 1000, zero period gives 0
    run_seq(0, 12345, 1, 1'b0);          // zero wait
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule